// File: doc/BRIEF.md
# Station next-hop dispatch controller

This block is the control logic for one stop on a shared routing network. A global message bus broadcasts orders of three fields: a vehicle ID, a destination stop ID and a next-hop stop ID. When an order is addressed to this stop, the block keeps the vehicle ID and the next hop in a small resettable order memory. A local sensor reports the ID of the vehicle currently standing at the stop, or zero when the stop is empty.

When the sensor shows a vehicle arriving (a change from zero to a nonzero ID) and that ID equals the stored vehicle ID, the block emits one dispatch message. The message names the vehicle, and its destination is the stored next hop. The order memory is cleared in the same step. Any other vehicle that stops here is invisible to the bus and leaves the stored order untouched. Both paths, the bus intake and the arrival detector, pass through one register stage, so they line up in time.

Top module: `stop_dispatch_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears the order memory, the arrival edge history and the dispatch outputs. After reset no arrival produces a dispatch until a new order has been accepted.
- R2: A bus order with `bus_valid` high whose vehicle ID is zero is ignored. Any order already held stays as it was.
- R3: A bus order whose destination is nonzero and differs from `STOP_ID` is ignored. Any order already held stays as it was.
- R4: With `ZERO_DEST_LOCAL` = 1, a destination of zero is accepted as if it equalled `STOP_ID`. With 0, only `STOP_ID` itself is accepted.
- R5: An accepted order stores its vehicle ID and its next-hop field. A later dispatch for it carries that vehicle ID on `out_vid` and that next hop on `out_dest`. This holds for every ID value up to all ones.
- R6: Only the rising edge of `stop_vid` (zero in one sampled cycle, nonzero in the next) counts as an arrival. A vehicle that keeps standing produces no further arrivals. An order for that vehicle that is accepted while it stands is dispatched only on its next arrival.
- R7: On a matching arrival, `out_valid` is high for exactly one cycle and the order memory is cleared. A second arrival of the same vehicle then produces nothing.
- R8: An arrival whose ID differs from the stored vehicle ID produces no dispatch and does not clear the stored order.
- R9: While `out_valid` is low, `out_vid` and `out_dest` are both zero.
- R10: A newly accepted order replaces any order already held. If an accept and a dispatch-clear take effect on the same edge, the new order is kept.
- R11: An arrival while no order is held never dispatches. `out_valid` high implies `out_vid` is nonzero.
- R12: An order sampled on clock edge e can be matched by an arrival first sampled on edge e+1 or later. A matching arrival first sampled on edge a raises `out_valid` after edge a+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus order is present this cycle |
| bus_vid | input | ID_W | Vehicle ID of the bus order (zero = none) |
| bus_dest | input | ID_W | Stop the bus order is addressed to |
| bus_hop | input | ID_W | Next hop the vehicle is sent to |
| stop_vid | input | ID_W | ID of the vehicle standing at this stop, zero when empty |
| out_valid | output | 1 | One-cycle dispatch strobe |
| out_vid | output | ID_W | Dispatched vehicle ID, zero when idle |
| out_dest | output | ID_W | Destination of the dispatch (stored next hop), zero when idle |

## Verification
The bench builds the block with `ID_W` = 4, `STOP_ID` = 5 and `ZERO_DEST_LOCAL` = 1. The narrow width brings the all-ones ID 15 into reach as both a vehicle and a hop. The zero-destination alias is enabled so that its acceptance path is exercised. A small stop number leaves room for foreign destinations such as 4. With these values, an accept and a dispatch-clear can be driven onto the same edge, and a vehicle can be held at the stop while a fresh order for it arrives.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

   // smallest ID width that leaves room for a nonzero stop and a foreign one
   localparam int MIN_ID_W = 2;

   // arrival edge: previous sample empty, current sample occupied
   function automatic logic rise_of(input logic prev_nz, input logic cur_nz);
      return cur_nz && !prev_nz;
   endfunction

endpackage

// File: rtl/dsp_ingress.sv
module dsp_ingress #(
   parameter int ID_W            = 8,
   parameter int STOP_ID         = 1,
   parameter int ZERO_DEST_LOCAL = 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            bus_valid,
   input  logic [ID_W-1:0] bus_vid,
   input  logic [ID_W-1:0] bus_dest,
   input  logic [ID_W-1:0] bus_hop,
   output logic            acc_q,
   output logic [ID_W-1:0] acc_vid_q,
   output logic [ID_W-1:0] acc_hop_q
);

   localparam logic [ID_W-1:0] OWN_ID = ID_W'(STOP_ID);

   logic dest_hit;

   generate
      if (ZERO_DEST_LOCAL != 0) begin : g_zero_local
         assign dest_hit = (bus_dest == OWN_ID) || (bus_dest == '0);
      end else begin : g_strict
         assign dest_hit = (bus_dest == OWN_ID);
      end
   endgenerate

   // one register stage aligns the bus path with the arrival path
   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q     <= 1'b0;
         acc_vid_q <= '0;
         acc_hop_q <= '0;
      end else begin
         acc_q     <= bus_valid && (bus_vid != '0) && dest_hit;
         acc_vid_q <= bus_vid;
         acc_hop_q <= bus_hop;
      end
   end

endmodule

// File: rtl/dsp_arrival.sv
module dsp_arrival #(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ID_W-1:0] stop_vid,
   output logic            arr_q,
   output logic [ID_W-1:0] arr_id_q
);

   logic [ID_W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q   <= '0;
         arr_q    <= 1'b0;
         arr_id_q <= '0;
      end else begin
         prev_q   <= stop_vid;
         arr_q    <= dsp_pkg::rise_of(prev_q != '0, stop_vid != '0);
         arr_id_q <= stop_vid;
      end
   end

endmodule

// File: rtl/dsp_order_mem.sv
module dsp_order_mem #(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [ID_W-1:0] wr_vid,
   input  logic [ID_W-1:0] wr_hop,
   input  logic            clr,
   output logic [ID_W-1:0] mem_vid,
   output logic [ID_W-1:0] mem_hop
);

   // a stored vehicle ID of zero means no order is held
   always_ff @(posedge clk) begin
      if (rst) begin
         mem_vid <= '0;
         mem_hop <= '0;
      end else if (wr_en) begin
         mem_vid <= wr_vid;
         mem_hop <= wr_hop;
      end else if (clr) begin
         mem_vid <= '0;
         mem_hop <= '0;
      end
   end

endmodule

// File: rtl/stop_dispatch_ctrl.sv
module stop_dispatch_ctrl #(
   parameter int ID_W            = 8,
   parameter int STOP_ID         = 1,
   parameter int ZERO_DEST_LOCAL = 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            bus_valid,
   input  logic [ID_W-1:0] bus_vid,
   input  logic [ID_W-1:0] bus_dest,
   input  logic [ID_W-1:0] bus_hop,
   input  logic [ID_W-1:0] stop_vid,
   output logic            out_valid,
   output logic [ID_W-1:0] out_vid,
   output logic [ID_W-1:0] out_dest
);

   generate
      if (ID_W < dsp_pkg::MIN_ID_W) begin : g_bad_width
         $error("stop_dispatch_ctrl: ID_W below minimum");
      end
      if (STOP_ID < 1 || STOP_ID >= (1 << ID_W)) begin : g_bad_stop
         $error("stop_dispatch_ctrl: STOP_ID must be nonzero and fit in ID_W");
      end
   endgenerate

   logic            acc_q;
   logic [ID_W-1:0] acc_vid_q;
   logic [ID_W-1:0] acc_hop_q;
   logic            arr_q;
   logic [ID_W-1:0] arr_id_q;
   logic [ID_W-1:0] mem_vid;
   logic [ID_W-1:0] mem_hop;
   logic            match;

   dsp_ingress #(
      .ID_W(ID_W), .STOP_ID(STOP_ID), .ZERO_DEST_LOCAL(ZERO_DEST_LOCAL)
   ) u_ingress (
      .clk(clk), .rst(rst),
      .bus_valid(bus_valid), .bus_vid(bus_vid), .bus_dest(bus_dest), .bus_hop(bus_hop),
      .acc_q(acc_q), .acc_vid_q(acc_vid_q), .acc_hop_q(acc_hop_q)
   );

   dsp_arrival #(.ID_W(ID_W)) u_arrival (
      .clk(clk), .rst(rst), .stop_vid(stop_vid),
      .arr_q(arr_q), .arr_id_q(arr_id_q)
   );

   dsp_order_mem #(.ID_W(ID_W)) u_mem (
      .clk(clk), .rst(rst),
      .wr_en(acc_q), .wr_vid(acc_vid_q), .wr_hop(acc_hop_q),
      .clr(match),
      .mem_vid(mem_vid), .mem_hop(mem_hop)
   );

   // a foreign arrival fails the compare and is filtered out entirely
   assign match = arr_q && (mem_vid != '0) && (arr_id_q == mem_vid);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_vid   <= '0;
         out_dest  <= '0;
      end else begin
         out_valid <= match;
         out_vid   <= match ? arr_id_q : '0;
         out_dest  <= match ? mem_hop  : '0;
      end
   end

endmodule

// File: rtl/stop_dispatch_chk.sv
module stop_dispatch_chk #(
   parameter int ID_W = 8
) (
   input logic            clk,
   input logic            rst,
   input logic [ID_W-1:0] stop_vid,
   input logic            out_valid,
   input logic [ID_W-1:0] out_vid,
   input logic [ID_W-1:0] out_dest
);

   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R1

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid); // R7

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (out_vid == '0 && out_dest == '0)); // R9

   AST_VID_NONZERO: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_vid != '0); // R11

   AST_EDGE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_vid == $past(stop_vid, 2) && $past(stop_vid, 3) == '0)); // R6

endmodule

bind stop_dispatch_ctrl stop_dispatch_chk #(.ID_W(ID_W)) u_chk (
   .clk(clk), .rst(rst), .stop_vid(stop_vid),
   .out_valid(out_valid), .out_vid(out_vid), .out_dest(out_dest)
);

// File: tb/stop_dispatch_ctrl_bench.sv
`timescale 1ns/1ps
module stop_dispatch_ctrl_bench;

   localparam int W    = 4;
   localparam int STOP = 5;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         bus_valid = 1'b0;
   logic [W-1:0] bus_vid = '0;
   logic [W-1:0] bus_dest = '0;
   logic [W-1:0] bus_hop = '0;
   logic [W-1:0] stop_vid = '0;
   logic         out_valid;
   logic [W-1:0] out_vid;
   logic [W-1:0] out_dest;

   int n_chk = 0;
   int n_err = 0;
   int disp_cnt = 0;
   int last_vid = 0;
   int last_dest = 0;
   bit started = 0;
   bit done = 0;

   always #2 clk = ~clk;

   stop_dispatch_ctrl #(.ID_W(W), .STOP_ID(STOP), .ZERO_DEST_LOCAL(1)) u_stop_dispatch_ctrl (
      .clk(clk), .rst(rst),
      .bus_valid(bus_valid), .bus_vid(bus_vid), .bus_dest(bus_dest), .bus_hop(bus_hop),
      .stop_vid(stop_vid),
      .out_valid(out_valid), .out_vid(out_vid), .out_dest(out_dest)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference: pending order, arrival stage, held order
   int m_acc, m_acc_vid, m_acc_hop, m_prev, m_arr, m_arr_id, m_vid, m_hop;
   int e_valid, e_vid, e_dest;

   always @(posedge clk) begin
      int hit;
      started = 1;
      if (rst) begin
         m_acc = 0; m_acc_vid = 0; m_acc_hop = 0; m_prev = 0; m_arr = 0; m_arr_id = 0;
         m_vid = 0; m_hop = 0; e_valid = 0; e_vid = 0; e_dest = 0;
      end else begin
         hit = (m_arr != 0 && m_vid != 0 && m_arr_id == m_vid) ? 1 : 0;
         e_valid = hit;
         e_vid   = hit ? m_arr_id : 0;
         e_dest  = hit ? m_hop : 0;
         if (m_acc != 0) begin
            m_vid = m_acc_vid; m_hop = m_acc_hop;
         end else if (hit != 0) begin
            m_vid = 0; m_hop = 0;
         end
         m_acc = (bus_valid && int'(bus_vid) != 0 &&
                  (int'(bus_dest) == STOP || int'(bus_dest) == 0)) ? 1 : 0;
         m_acc_vid = int'(bus_vid);
         m_acc_hop = int'(bus_hop);
         m_arr = (int'(stop_vid) != 0 && m_prev == 0) ? 1 : 0;
         m_arr_id = int'(stop_vid);
         m_prev = int'(stop_vid);
      end
   end

   // per-cycle comparison against the reference (R12 timing, R9 idle zeros)
   always @(negedge clk) begin
      if (started && !done) begin
         chk("R12 out_valid", int'(out_valid), e_valid);
         chk("R12 out_vid", int'(out_vid), e_vid);
         chk("R5 out_dest", int'(out_dest), e_dest);
         if (!out_valid) chk("R9 idle fields", int'(out_vid) + int'(out_dest), 0);
         if (out_valid) begin
            disp_cnt++;
            last_vid  = int'(out_vid);
            last_dest = int'(out_dest);
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(int vid, int dest, int hop);
      bus_valid = 1'b1; bus_vid = W'(vid); bus_dest = W'(dest); bus_hop = W'(hop);
      cyc(1);
      bus_valid = 1'b0; bus_vid = '0; bus_dest = '0; bus_hop = '0;
   endtask

   task automatic park(int vid, int n);
      stop_vid = W'(vid);
      cyc(n);
      stop_vid = '0;
      cyc(3);
   endtask

   task automatic expect_disp(string req, int base, int cnt, int vid, int dest);
      chk({req, " dispatch count"}, disp_cnt - base, cnt);
      if (cnt != 0) begin
         chk({req, " vid"}, last_vid, vid);
         chk({req, " dest"}, last_dest, dest);
      end
   endtask

   initial begin
      int b;
      cyc(3);
      chk("R1 reset out_valid", int'(out_valid), 0);
      chk("R1 reset fields", int'(out_vid) + int'(out_dest), 0);
      rst = 1'b0;
      cyc(1);

      // R1 / R11: nothing held after reset, arrival stays silent
      b = disp_cnt; park(3, 5); expect_disp("R11", b, 0, 0, 0);

      // R5 / R6: one dispatch despite a five-cycle stay
      b = disp_cnt; send(3, STOP, 9); park(3, 5); expect_disp("R6", b, 1, 3, 9);

      // R7: memory cleared, second arrival silent
      b = disp_cnt; park(3, 4); expect_disp("R7", b, 0, 0, 0);

      // R2: zero vehicle ID does not overwrite the held order
      b = disp_cnt; send(6, STOP, 2); send(0, STOP, 7); park(6, 4);
      expect_disp("R2", b, 1, 6, 2);

      // R3: foreign destination ignored, held order kept
      b = disp_cnt; send(7, 4, 1); park(7, 4); expect_disp("R3 foreign", b, 0, 0, 0);
      b = disp_cnt; send(8, STOP, 3); send(9, 4, 4); park(8, 4);
      expect_disp("R3 kept", b, 1, 8, 3);

      // R4: destination zero treated as local
      b = disp_cnt; send(10, 0, 12); park(10, 4); expect_disp("R4", b, 1, 10, 12);

      // R8: foreign arrival is silent and keeps the order
      b = disp_cnt; send(11, STOP, 13); park(2, 4); expect_disp("R8 foreign", b, 0, 0, 0);
      b = disp_cnt; park(11, 4); expect_disp("R8 kept", b, 1, 11, 13);

      // R10: newer order replaces the older one
      b = disp_cnt; send(12, STOP, 1); send(13, STOP, 2); park(12, 4);
      expect_disp("R10 old gone", b, 0, 0, 0);
      b = disp_cnt; park(13, 4); expect_disp("R10 new", b, 1, 13, 2);

      // R10: accept and clear on the same edge, new order survives
      send(14, STOP, 3);
      b = disp_cnt;
      bus_valid = 1'b1; bus_vid = W'(15); bus_dest = W'(STOP); bus_hop = W'(6);
      stop_vid = W'(14);
      cyc(1);
      bus_valid = 1'b0; bus_vid = '0; bus_dest = '0; bus_hop = '0;
      cyc(3); stop_vid = '0; cyc(3);
      expect_disp("R10 same edge", b, 1, 14, 3);
      b = disp_cnt; park(15, 4); expect_disp("R10 survivor", b, 1, 15, 6);

      // R6: order accepted while the vehicle stands waits for the next arrival
      b = disp_cnt; send(4, STOP, 8);
      stop_vid = W'(4); cyc(4);
      send(4, STOP, 9); cyc(5);
      expect_disp("R6 first", b, 1, 4, 8);
      stop_vid = '0; cyc(3);
      expect_disp("R6 no re-fire", b, 1, 4, 8);
      b = disp_cnt; park(4, 3); expect_disp("R6 next arrival", b, 1, 4, 9);

      // R5: all-ones IDs
      b = disp_cnt; send(15, STOP, 15); park(15, 2); expect_disp("R5 max", b, 1, 15, 15);

      // R12: arrival sampled one edge after the order still matches
      b = disp_cnt;
      bus_valid = 1'b1; bus_vid = W'(1); bus_dest = W'(STOP); bus_hop = W'(14);
      cyc(1);
      bus_valid = 1'b0; bus_vid = '0; bus_dest = '0; bus_hop = '0;
      stop_vid = W'(1);
      cyc(2);
      chk("R12 strobe timing", int'(out_valid), 1);
      cyc(2); stop_vid = '0; cyc(3);
      expect_disp("R12", b, 1, 1, 14);

      // R1: mid-run reset drops the held order
      b = disp_cnt; send(3, STOP, 9);
      rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
      park(3, 4); expect_disp("R1 mid reset", b, 0, 0, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule